// File: doc/BRIEF.md
# Interrupt Pin Pending and End-of-Interrupt Tracker

This block watches a set of interrupt input lines and decides when each one must be handed to the delivery logic. Each pin has a configuration slot supplied from outside: a mask bit, a polarity bit, a trigger-mode bit, a vector and a destination. The block applies the polarity and keeps a pending bit per pin. It raises one delivery request at a time, and each request carries the pin's index, vector, destination and trigger mode.

Edge-mode pins are delivered once for each rising transition of their effective level. Level-mode pins are throttled by an in-service flag. The flag is set when the pin is captured for delivery. It is cleared by an end-of-interrupt notice whose vector selects that pin. When the line is still asserted after the flag clears, the pin is delivered again. Requests leave through a valid/ready handshake. A stalled consumer holds the request in place and keeps the pending state intact. Destination decoding and the configuration register interface are not part of this block.

Top module: `irq_pend_eoi`

## Requirements
- R1: After reset, every pending bit and every in-service bit is 0 and `dlv_valid` is 0.
- R2: A pin's effective level is `pin_in[i]` XOR `cfg_pol[i]`. For a level-mode pin (`cfg_trig[i]`=1), `pend_o[i]` shows the effective level sampled one clock earlier.
- R3: An edge-mode pin (`cfg_trig[i]`=0) that is unmasked becomes pending when its effective level rises. Its pending bit clears when the pin is captured for delivery, or whenever its effective level is low. Holding the line high produces exactly one delivery, and a pulse that falls before capture produces none.
- R4: A rising effective level on a masked edge-mode pin is not recorded. No pending bit is set and no delivery follows.
- R5: An unmasked level-mode pin whose pending bit is set and whose in-service bit (`rirr_o[i]`) is clear is captured for delivery, and capture sets its in-service bit. No further delivery of that pin happens while the bit stays set.
- R6: A masked level-mode pin is never captured and its in-service bit is unchanged. When it is unmasked while its pending bit is set, it is delivered.
- R7: An end-of-interrupt notice (`eoi_valid` with `eoi_vec`) clears the in-service bit of the lowest-numbered pin whose `cfg_vec` equals `eoi_vec`. A pin with a higher index and the same vector is not touched. A vector that matches no pin changes nothing.
- R8: A level-mode pin whose line is still asserted after its in-service bit is cleared is delivered again.
- R9: When several pins need service together, they are delivered in ascending index order, one per accepted handshake.
- R10: While `dlv_valid` is 1 and `dlv_ready` is 0, all `dlv_*` outputs hold their values and no pending bit is dropped by the stall.
- R11: A delivery carries the captured pin's index in `dlv_pin`, its `cfg_vec` slice in `dlv_vec`, its `cfg_dest` slice in `dlv_dest` and its trigger mode in `dlv_level`. It appears at the ports one clock after the pending bit is first visible, provided the output slot is free.
- R12: If an end-of-interrupt notice for a level-mode pin arrives in the same clock as that pin's capture, the capture wins and the in-service bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Raw interrupt lines |
| cfg_mask | input | NPINS | Per-pin mask (1 = masked) |
| cfg_pol | input | NPINS | Per-pin polarity (1 = active low) |
| cfg_trig | input | NPINS | Per-pin trigger mode (1 = level, 0 = edge) |
| cfg_vec | input | NPINS*VEC_W | Per-pin vector, pin i at slice i |
| cfg_dest | input | NPINS*DEST_W | Per-pin destination, pin i at slice i |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vec | input | VEC_W | Vector of the end-of-interrupt notice |
| dlv_valid | output | 1 | Delivery request present |
| dlv_ready | input | 1 | Consumer accepts the request |
| dlv_pin | output | IDX_W | Index of the delivered pin |
| dlv_vec | output | VEC_W | Vector of the delivered pin |
| dlv_dest | output | DEST_W | Destination of the delivered pin |
| dlv_level | output | 1 | Delivered pin is level-mode |
| pend_o | output | NPINS | Pending bits |
| rirr_o | output | NPINS | In-service bits of level-mode pins |

## Verification
Two functions can coincide in one cycle: capture of a level-mode pin, which sets its in-service bit, and an end-of-interrupt notice for the same vector, which clears that bit. The bench raises a level pin and, in the clock where its pending bit first becomes visible, presents the matching notice. It then checks that the pin was delivered, that the in-service bit reads 1, and that no second delivery follows. A second coincidence arises when a handshake completes and the next pin is captured in the same clock. This is judged by the order and the absence of gaps in a multi-pin burst that is released after a stall.

// File: rtl/irq_pend_eoi.sv
module irq_pend_eoi #(
  parameter int NPINS  = 8,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPINS-1:0]          pin_in,
  input  logic [NPINS-1:0]          cfg_mask,
  input  logic [NPINS-1:0]          cfg_pol,
  input  logic [NPINS-1:0]          cfg_trig,
  input  logic [NPINS*VEC_W-1:0]    cfg_vec,
  input  logic [NPINS*DEST_W-1:0]   cfg_dest,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vec,
  output logic                      dlv_valid,
  input  logic                      dlv_ready,
  output logic [IDX_W-1:0]          dlv_pin,
  output logic [VEC_W-1:0]          dlv_vec,
  output logic [DEST_W-1:0]         dlv_dest,
  output logic                      dlv_level,
  output logic [NPINS-1:0]          pend_o,
  output logic [NPINS-1:0]          rirr_o
);

  logic [NPINS-1:0] eff, prev_q, pend_q, rirr_q, need, ld_vec, eoi_hit;
  logic [NPINS-1:0] pend_n, rirr_n;
  logic [IDX_W-1:0] ld_idx, eoi_idx;
  logic             ld, eoi_any, out_v;

  assign eff = pin_in ^ cfg_pol;

  // edge pins wait on pend alone; level pins also wait on the in-service bit
  assign need = pend_q & ~cfg_mask & (~cfg_trig | ~rirr_q);

  always_comb begin
    ld_idx = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (need[i]) ld_idx = IDX_W'(i);
  end

  always_comb begin
    eoi_idx = '0;
    eoi_any = 1'b0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (cfg_vec[i*VEC_W +: VEC_W] == eoi_vec) begin
        eoi_idx = IDX_W'(i);
        eoi_any = 1'b1;
      end
  end

  assign ld = (|need) && (!out_v || dlv_ready);

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
      assign ld_vec[g]  = ld && (ld_idx == IDX_W'(g));
      assign eoi_hit[g] = eoi_valid && eoi_any && (eoi_idx == IDX_W'(g));
      assign pend_n[g]  = cfg_trig[g] ? eff[g]
                        : eff[g] & ((pend_q[g] & ~ld_vec[g]) | (~prev_q[g] & ~cfg_mask[g]));
      assign rirr_n[g]  = (ld_vec[g] && cfg_trig[g]) ? 1'b1
                        : (eoi_hit[g] ? 1'b0 : rirr_q[g]);

      AST_MASKED_EDGE_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mask[g] && !cfg_trig[g] && !pend_q[g]) |=> !pend_q[g]); // R4
      AST_RIRR_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !rirr_q[g] |=> (!rirr_q[g] || $past(ld_vec[g] && cfg_trig[g]))); // R5
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      rirr_q <= '0;
    end else begin
      prev_q <= eff;
      pend_q <= pend_n;
      rirr_q <= rirr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v     <= 1'b0;
      dlv_pin   <= '0;
      dlv_vec   <= '0;
      dlv_dest  <= '0;
      dlv_level <= 1'b0;
    end else if (ld) begin
      out_v     <= 1'b1;
      dlv_pin   <= ld_idx;
      dlv_vec   <= cfg_vec[ld_idx*VEC_W +: VEC_W];
      dlv_dest  <= cfg_dest[ld_idx*DEST_W +: DEST_W];
      dlv_level <= cfg_trig[ld_idx];
    end else if (dlv_ready) begin
      out_v <= 1'b0;
    end
  end

  assign dlv_valid = out_v;
  assign pend_o    = pend_q;
  assign rirr_o    = rirr_q;

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && !dlv_ready) |=> (out_v && $stable(dlv_pin) && $stable(dlv_vec)
                               && $stable(dlv_dest) && $stable(dlv_level))); // R10
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> ((need & ((NPINS'(1) << ld_idx) - NPINS'(1))) == '0)); // R9
  AST_LEVEL_LOAD_SETS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && cfg_trig[ld_idx]) |=> rirr_q[dlv_pin]); // R12
  AST_NO_LOAD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && !dlv_ready) |-> !ld); // R10

endmodule

// File: tb/test_irq_pend_eoi.sv
`timescale 1ns/1ps
module test_irq_pend_eoi;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pin_in, cfg_mask, cfg_pol, cfg_trig, pend_o, rirr_o;
  logic [N*8-1:0] cfg_vec, cfg_dest;
  logic eoi_valid, dlv_valid, dlv_ready, dlv_level;
  logic [7:0] eoi_vec, dlv_vec, dlv_dest;
  logic [IW-1:0] dlv_pin;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_pend_eoi #(.NPINS(N), .VEC_W(8), .DEST_W(8)) i_irq_pend_eoi (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_mask(cfg_mask),
    .cfg_pol(cfg_pol), .cfg_trig(cfg_trig), .cfg_vec(cfg_vec), .cfg_dest(cfg_dest),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_pin(dlv_pin), .dlv_vec(dlv_vec),
    .dlv_dest(dlv_dest), .dlv_level(dlv_level), .pend_o(pend_o), .rirr_o(rirr_o));

  // pins, eoi_v, eoi_vec, ready, exp_valid, exp_pin, exp_pend, exp_rirr
  localparam logic [37:0] TAB [0:11] = '{
    {8'h41, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 8'h01, 8'h00},
    {8'h41, 1'b0, 8'h00, 1'b1, 1'b1, 3'd0, 8'h00, 8'h00},
    {8'h40, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00, 8'h00},
    {8'h50, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 8'h10, 8'h00},
    {8'h50, 1'b0, 8'h00, 1'b1, 1'b1, 3'd4, 8'h10, 8'h10},
    {8'h50, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 8'h10, 8'h10},
    {8'h50, 1'b1, 8'h24, 1'b1, 1'b0, 3'd0, 8'h10, 8'h00},
    {8'h50, 1'b0, 8'h00, 1'b1, 1'b1, 3'd4, 8'h10, 8'h10},
    {8'h40, 1'b0, 8'h00, 1'b0, 1'b1, 3'd4, 8'h00, 8'h10},
    {8'h40, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00, 8'h10},
    {8'h40, 1'b1, 8'h24, 1'b1, 1'b0, 3'd0, 8'h00, 8'h00},
    {8'h40, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00, 8'h00}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_valid = 1'b1; eoi_vec = v; tick; eoi_valid = 1'b0;
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg_mask = 8'h22; cfg_pol = 8'h40; cfg_trig = 8'hF0;
    for (int i = 0; i < N; i++) begin
      cfg_vec[i*8 +: 8]  = (i == 7) ? 8'h24 : 8'(8'h20 + i);
      cfg_dest[i*8 +: 8] = 8'(8'h80 + i);
    end
    pin_in = 8'h40; eoi_valid = 1'b0; eoi_vec = 8'h00; dlv_ready = 1'b1;
    tick; tick; tick;
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 valid", 32'(dlv_valid), 0);
    chk("R1 pend", 32'(pend_o), 0);
    chk("R1 rirr", 32'(rirr_o), 0);

    // table: edge pin 0 then level pin 4 with EOI re-delivery (R3, R5, R8, R10, R7)
    for (int s = 0; s < 12; s++) begin
      pin_in = TAB[s][37:30]; eoi_valid = TAB[s][29]; eoi_vec = TAB[s][28:21];
      dlv_ready = TAB[s][20];
      tick;
      chk("R3/R5/R8 table valid", 32'(dlv_valid), 32'(TAB[s][19]));
      if (TAB[s][19]) chk("R9 table pin", 32'(dlv_pin), 32'(TAB[s][18:16]));
      chk("R2/R3 table pend", 32'(pend_o), 32'(TAB[s][15:8]));
      chk("R5/R7 table rirr", 32'(rirr_o), 32'(TAB[s][7:0]));
    end
    eoi_valid = 1'b0; dlv_ready = 1'b1;

    // R2 polarity on level pin 6 (active low), R11 fields
    pin_in = 8'h00; tick;
    chk("R2 pend6", 32'(pend_o), 32'h40);
    tick;
    chk("R11 valid", 32'(dlv_valid), 1);
    chk("R11 pin", 32'(dlv_pin), 6);
    chk("R11 vec", 32'(dlv_vec), 32'h26);
    chk("R11 dest", 32'(dlv_dest), 32'h86);
    chk("R11 level", 32'(dlv_level), 1);
    chk("R5 rirr6", 32'(rirr_o), 32'h40);
    pin_in = 8'h40; tick;
    eoi(8'h26);
    chk("R7 rirr6 cleared", 32'(rirr_o), 0);

    // R4 masked edge pin 1
    pin_in = 8'h42;
    for (int k = 0; k < 3; k++) begin
      tick;
      chk("R4 pend", 32'(pend_o), 0);
      chk("R4 valid", 32'(dlv_valid), 0);
    end
    pin_in = 8'h40; tick;

    // R6 masked level pin 5, then unmask
    pin_in = 8'h60; tick;
    chk("R6 pend5", 32'(pend_o), 32'h20);
    tick; tick;
    chk("R6 masked valid", 32'(dlv_valid), 0);
    chk("R6 masked rirr", 32'(rirr_o), 0);
    cfg_mask[5] = 1'b0; tick;
    chk("R6 unmask valid", 32'(dlv_valid), 1);
    chk("R6 unmask pin", 32'(dlv_pin), 5);
    cfg_mask[5] = 1'b1; pin_in = 8'h40; tick;
    eoi(8'h25);
    chk("R6 cleanup rirr", 32'(rirr_o), 0);

    // R9 ordering with R10 stall
    pin_in = 8'h4D; tick;
    chk("R9 pend", 32'(pend_o), 32'h0D);
    tick;
    chk("R9 first pin", 32'(dlv_pin), 0);
    dlv_ready = 1'b0; tick; tick;
    chk("R10 stall valid", 32'(dlv_valid), 1);
    chk("R10 stall pin", 32'(dlv_pin), 0);
    chk("R10 stall pend", 32'(pend_o), 32'h0C);
    dlv_ready = 1'b1; tick;
    chk("R9 second pin", 32'(dlv_pin), 2);
    tick;
    chk("R9 third pin", 32'(dlv_pin), 3);
    chk("R9 third valid", 32'(dlv_valid), 1);
    tick;
    chk("R3 held high no repeat", 32'(dlv_valid), 0);
    pin_in = 8'h40; tick;

    // R3 pulse dropped before capture
    pin_in = 8'h41; dlv_ready = 1'b0; tick; tick;
    chk("R3 slot busy", 32'(dlv_pin), 0);
    pin_in = 8'h44; tick;
    chk("R3 pulse pend", 32'(pend_o), 32'h04);
    pin_in = 8'h40; tick;
    chk("R3 pulse cleared", 32'(pend_o), 0);
    dlv_ready = 1'b1; tick; tick;
    chk("R3 no pulse delivery", 32'(dlv_valid), 0);

    // R12 EOI coinciding with capture of pin 4
    pin_in = 8'h50; tick;
    eoi(8'h24);
    chk("R12 delivered", 32'(dlv_pin), 4);
    chk("R12 rirr wins", 32'(rirr_o), 32'h10);
    tick;
    chk("R12 no repeat", 32'(dlv_valid), 0);
    pin_in = 8'h40; tick;
    eoi(8'h24);
    chk("R12 cleanup", 32'(rirr_o), 0);

    // R7 lowest vector match (pins 4 and 7 share vector 0x24)
    pin_in = 8'hD0; tick; tick;
    chk("R7 pin4 first", 32'(dlv_pin), 4);
    tick;
    chk("R7 pin7 vec", 32'(dlv_vec), 32'h24);
    chk("R11 pin7 dest", 32'(dlv_dest), 32'h87);
    tick;
    chk("R7 both rirr", 32'(rirr_o), 32'h90);
    pin_in = 8'h40; tick;
    eoi(8'h24);
    chk("R7 lowest cleared", 32'(rirr_o), 32'h80);
    eoi(8'h24);
    chk("R7 higher untouched", 32'(rirr_o), 32'h80);
    eoi(8'h99);
    chk("R7 no match ignored", 32'(rirr_o), 32'h80);
    chk("R7 no match pend", 32'(pend_o), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule